// File: doc/BRIEF.md
# Interrupt Gate Lookup Unit

This block turns an interrupt vector number into the entry point of its handler for a CPU core. A request carries the vector, the class of event that raised it (hardware interrupt, processor exception or a software interrupt instruction), the current privilege level of the core and the current table base and limit. In the protected table format the unit reads the 16-byte gate for the vector through a 64-bit read port. It takes the low half first and the high half second. It then checks the entry against the table limit, the gate type, the privilege of the caller and the present flag.

A request that passes every check returns the 64-bit handler address, the code selector, the stack-table index and whether the interrupt-enable flag is to be cleared on entry. A request that fails a check returns a fault vector and an error code in place of a dispatch. A real-mode request instead reads a 4-byte segment:offset pair from a table at address zero and computes a 20-bit linear handler address. Stack switching, frame pushes and segment loading are left to the core.

Top module: `idt_gate_lookup`

## Requirements
- R1: After a synchronous reset, and also when reset is applied in the middle of a fetch, the unit is idle: `req_ready`=1, `rd_req`=0, `done`=0, `fault`=0 and the result outputs are zero.
- R2: A request is taken only in a cycle where `req_ready` is 1. `req_ready` stays 0 while a fetch is in progress, and the vector, class and privilege presented during that time have no effect on the result.
- R3: In protected format, vector n is fetched as two reads: byte address base+16n first, then base+16n+8. Each read keeps `rd_req` and `rd_addr` steady until `rd_ack`. The read port returns the 8 bytes that start at `rd_addr`, little-endian, in the cycle of `rd_ack`. `done` is high for exactly one cycle: the cycle right after the second acknowledge.
- R4: A dispatch takes the handler address from bytes 0-1 (bits 15:0), bytes 6-7 (bits 31:16) and bytes 8-11 (bits 63:32). The selector comes from bytes 2-3 and the stack-table index from bits 2:0 of byte 4. The other bits of byte 4 and bytes 12-15 are ignored.
- R5: Byte 5 holds the present flag in bit 7, the gate privilege in bits 6:5 and the gate type in bits 3:0. Type 0xE gives `clear_if`=1 and type 0xF gives `clear_if`=0. Any other type raises fault vector 13.
- R6: If 16n+15 is greater than the table limit, the unit raises fault vector 13 without issuing any read, and `done` rises in the cycle right after the request is taken.
- R7: Event class encoding: 0 = hardware interrupt, 1 = exception, 2 = software interrupt. Only class 2 compares privilege, and it raises fault vector 13 when the current level is numerically greater than the gate privilege. Classes 0 and 1 never fault on privilege.
- R8: A gate whose present flag is 0 raises fault vector 11. The checks are taken in this order: limit, then type, then privilege, then present. The first failing check decides the fault vector.
- R9: Every fault reports the error code n*8+2 on `err_code`, with handler, selector, stack index and `clear_if` all zero.
- R10: A real-mode request makes one read at byte address 4n. The offset is bits 15:0 of the returned data and the segment is bits 31:16. The result is handler = segment*16+offset, selector = segment, stack index 0, `clear_if`=1. No limit, type, privilege or present check applies, and `done` rises in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_vector | input | VEC_W | Vector number n |
| req_src | input | 2 | Event class (0 hw, 1 exception, 2 software) |
| req_cpl | input | 2 | Current privilege level |
| req_real | input | 1 | Use the real-mode far-pointer table |
| tbl_base | input | ADDR_W | Protected table base byte address |
| tbl_limit | input | LIMIT_W | Protected table size in bytes minus one |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ack | input | 1 | Read accepted, data valid this cycle |
| rd_data | input | 64 | Read data, 8 bytes little-endian |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Result is a fault |
| fault_vec | output | 8 | Fault vector (11 or 13) |
| err_code | output | 16 | Fault error code n*8+2 |
| handler | output | 64 | Handler linear address |
| selector | output | 16 | Handler code selector |
| stack_idx | output | 3 | Stack-table index, 0 for none |
| clear_if | output | 1 | Clear interrupt-enable flag on entry |

## Verification
The assertions assume that the memory side raises `rd_ack` only while `rd_req` is high and for one cycle per read. They also assume that the data a read returns belongs to the address on `rd_addr` in that same cycle. The bench memory model follows these rules: it answers only a pending read, adds a stall of zero to a few cycles, and computes each returned word from its address. The model also lets the bench set the type, privilege and present fields of each gate. Requests are presented only while `req_ready` is high. During the busy test, extra vectors are held on the request pins only while the unit reports itself busy, and they are dropped in the `done` cycle.

// File: rtl/idt_lookup_pkg.sv
package idt_lookup_pkg;

   typedef enum logic [1:0] {
      SRC_HWIRQ  = 2'd0,
      SRC_EXCEPT = 2'd1,
      SRC_SOFT   = 2'd2,
      SRC_RSVD   = 2'd3
   } src_e;

   localparam logic [7:0] VEC_NOT_PRESENT = 8'd11;
   localparam logic [7:0] VEC_PROT        = 8'd13;
   localparam logic [3:0] GATE_INTR       = 4'hE;
   localparam logic [3:0] GATE_TRAP       = 4'hF;

   typedef struct packed {
      logic        fault;
      logic [7:0]  fvec;
      logic [15:0] err;
      logic [63:0] hnd;
      logic [15:0] sel;
      logic [2:0]  ist;
      logic        clr_if;
   } gate_res_t;

   function automatic logic [15:0] err_of(input logic [7:0] v);
      return {5'b0, v, 3'b010};
   endfunction

   function automatic gate_res_t fault_res(input logic [7:0] fv, input logic [15:0] ec);
      gate_res_t r;
      r       = '0;
      r.fault = 1'b1;
      r.fvec  = fv;
      r.err   = ec;
      return r;
   endfunction

endpackage

// File: rtl/idt_fetch_ctrl.sv
module idt_fetch_ctrl #(
   parameter int VEC_W   = 8,
   parameter int ADDR_W  = 64,
   parameter int LIMIT_W = 16,
   parameter int REAL_EN = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VEC_W-1:0]   req_vector,
   input  logic [1:0]         req_src,
   input  logic [1:0]         req_cpl,
   input  logic               req_real,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [LIMIT_W-1:0] tbl_limit,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_ack,
   input  logic [63:0]        rd_data,
   output logic [63:0]        lo_q,
   output logic [VEC_W-1:0]   vec_q,
   output logic [1:0]         src_q,
   output logic [1:0]         cpl_q,
   output logic               fin_desc,
   output logic               fin_real,
   output logic               fin_limit
);

   typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_RM} st_e;

   st_e               st_q;
   logic [ADDR_W-1:0] base_q;
   logic              real_sel;
   logic              accept;
   logic              beyond;

   generate
      if (REAL_EN != 0) begin : g_real
         assign real_sel = req_real;
      end else begin : g_prot_only
         assign real_sel = 1'b0;
      end
   endgenerate

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign beyond    = LIMIT_W'({req_vector, 4'hF}) > tbl_limit;
   assign rd_req    = (st_q != ST_IDLE);

   assign fin_desc  = (st_q == ST_HI) && rd_ack;
   assign fin_real  = (st_q == ST_RM) && rd_ack;
   assign fin_limit = accept && !real_sel && beyond;

   always_comb begin
      case (st_q)
         ST_LO:   rd_addr = base_q + ADDR_W'({vec_q, 4'h0});
         ST_HI:   rd_addr = base_q + ADDR_W'({vec_q, 4'h8});
         ST_RM:   rd_addr = ADDR_W'({vec_q, 2'b00});
         default: rd_addr = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         base_q <= '0;
         vec_q  <= '0;
         src_q  <= '0;
         cpl_q  <= '0;
         lo_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  vec_q  <= req_vector;
                  src_q  <= req_src;
                  cpl_q  <= req_cpl;
                  base_q <= tbl_base;
                  if (real_sel)    st_q <= ST_RM;
                  else if (beyond) st_q <= ST_IDLE;
                  else             st_q <= ST_LO;
               end
            end
            ST_LO: begin
               if (rd_ack) begin
                  lo_q <= rd_data;
                  st_q <= ST_HI;
               end
            end
            ST_HI:   if (rd_ack) st_q <= ST_IDLE;
            ST_RM:   if (rd_ack) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/idt_gate_decode.sv
module idt_gate_decode
   import idt_lookup_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic [63:0]      lo,
   input  logic [63:0]      hi,
   input  logic [VEC_W-1:0] vec,
   input  logic [1:0]       src,
   input  logic [1:0]       cpl,
   output gate_res_t        res
);

   logic        present;
   logic [1:0]  dpl;
   logic [3:0]  gtype;
   logic        type_ok;
   logic        priv_ok;
   logic [15:0] ecode;
   logic        unused_rsvd;

   assign present     = lo[47];
   assign dpl         = lo[46:45];
   assign gtype       = lo[43:40];
   assign type_ok     = (gtype == GATE_INTR) || (gtype == GATE_TRAP);
   assign priv_ok     = (src != SRC_SOFT) || (cpl <= dpl);
   assign ecode       = err_of(8'(vec));
   assign unused_rsvd = ^{lo[39:35], lo[44], hi[63:32]};

   always_comb begin
      res = '0;
      if (!type_ok || !priv_ok) begin
         res = fault_res(VEC_PROT, ecode);
      end else if (!present) begin
         res = fault_res(VEC_NOT_PRESENT, ecode);
      end else begin
         res.hnd    = {hi[31:0], lo[63:48], lo[15:0]};
         res.sel    = lo[31:16];
         res.ist    = lo[34:32];
         res.clr_if = (gtype == GATE_INTR);
      end
   end

endmodule

// File: rtl/idt_realmode_decode.sv
module idt_realmode_decode
   import idt_lookup_pkg::*;
(
   input  logic [31:0] word,
   output gate_res_t   res
);

   logic [15:0] seg;
   logic [15:0] ofs;

   assign seg = word[31:16];
   assign ofs = word[15:0];

   always_comb begin
      res        = '0;
      res.hnd    = 64'({seg, 4'h0}) + 64'(ofs);
      res.sel    = seg;
      res.clr_if = 1'b1;
   end

endmodule

// File: rtl/idt_gate_lookup.sv
module idt_gate_lookup
   import idt_lookup_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int ADDR_W  = 64,
   parameter int LIMIT_W = 16,
   parameter int REAL_EN = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VEC_W-1:0]   req_vector,
   input  logic [1:0]         req_src,
   input  logic [1:0]         req_cpl,
   input  logic               req_real,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [LIMIT_W-1:0] tbl_limit,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_ack,
   input  logic [63:0]        rd_data,
   output logic               done,
   output logic               fault,
   output logic [7:0]         fault_vec,
   output logic [15:0]        err_code,
   output logic [63:0]        handler,
   output logic [15:0]        selector,
   output logic [2:0]         stack_idx,
   output logic               clear_if
);

   generate
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
         $error("VEC_W must lie in 1..8");
      end
      if (LIMIT_W < VEC_W + 4) begin : g_bad_limit
         $error("LIMIT_W must cover a full table of VEC_W vectors");
      end
      if (ADDR_W < VEC_W + 5 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
   endgenerate

   logic [63:0]      lo_q;
   logic [VEC_W-1:0] vec_q;
   logic [1:0]       src_q;
   logic [1:0]       cpl_q;
   logic             fin_desc;
   logic             fin_real;
   logic             fin_limit;
   gate_res_t        desc_res;
   gate_res_t        rm_res;
   gate_res_t        res_q;
   logic             done_q;

   idt_fetch_ctrl #(
      .VEC_W(VEC_W), .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .REAL_EN(REAL_EN)
   ) u_ctrl (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vector(req_vector), .req_src(req_src), .req_cpl(req_cpl),
      .req_real(req_real), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .lo_q(lo_q), .vec_q(vec_q), .src_q(src_q), .cpl_q(cpl_q),
      .fin_desc(fin_desc), .fin_real(fin_real), .fin_limit(fin_limit)
   );

   idt_gate_decode #(.VEC_W(VEC_W)) u_dec (
      .lo(lo_q), .hi(rd_data), .vec(vec_q), .src(src_q), .cpl(cpl_q),
      .res(desc_res)
   );

   generate
      if (REAL_EN != 0) begin : g_rm_dec
         idt_realmode_decode u_rm (.word(rd_data[31:0]), .res(rm_res));
      end else begin : g_rm_none
         assign rm_res = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= fin_desc || fin_real || fin_limit;
         if (fin_limit)     res_q <= fault_res(VEC_PROT, err_of(8'(req_vector)));
         else if (fin_desc) res_q <= desc_res;
         else if (fin_real) res_q <= rm_res;
      end
   end

   assign done      = done_q;
   assign fault     = res_q.fault;
   assign fault_vec = res_q.fvec;
   assign err_code  = res_q.err;
   assign handler   = res_q.hnd;
   assign selector  = res_q.sel;
   assign stack_idx = res_q.ist;
   assign clear_if  = res_q.clr_if;

endmodule

// File: rtl/idt_lookup_chk.sv
module idt_lookup_chk #(
   parameter int VEC_W   = 8,
   parameter int ADDR_W  = 64,
   parameter int REAL_EN = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [VEC_W-1:0]  req_vector,
   input logic              req_real,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic              done,
   input logic              fault,
   input logic [7:0]        fault_vec,
   input logic [15:0]       err_code
);

   logic [VEC_W-1:0] vec_c;
   logic             real_c;
   logic [1:0]       beats_c;
   logic             beat;

   assign beat = rd_req && rd_ack;

   always_ff @(posedge clk) begin
      if (rst) begin
         vec_c   <= '0;
         real_c  <= 1'b0;
         beats_c <= '0;
      end else if (req_valid && req_ready) begin
         vec_c   <= req_vector;
         real_c  <= (REAL_EN != 0) && req_real;
         beats_c <= '0;
      end else if (beat) begin
         beats_c <= beats_c + 2'd1;
      end
   end

   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> !rd_req) else $error("idle unit issued a read"); // R2

   AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))) else $error("read dropped or moved"); // R3

   AST_DONE_AFTER_BEAT2: assert property (@(posedge clk) disable iff (rst)
      (beat && beats_c == 2'd1 && !real_c) |=> done) else $error("no done after second beat"); // R3

   AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (rst)
      done |-> !rd_req) else $error("done while reading"); // R3

   AST_REAL_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
      (beat && real_c) |=> done) else $error("real-mode done late"); // R10

   AST_FAULT_VEC: assert property (@(posedge clk) disable iff (rst)
      (done && fault) |-> (fault_vec == 8'd11 || fault_vec == 8'd13)) else $error("bad fault vector"); // R8

   AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
      (done && fault) |-> (err_code == {5'b0, 8'(vec_c), 3'b010})) else $error("bad error code"); // R9

endmodule

bind idt_gate_lookup idt_lookup_chk #(
   .VEC_W(VEC_W), .ADDR_W(ADDR_W), .REAL_EN(REAL_EN)
) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .req_vector(req_vector), .req_real(req_real), .rd_req(rd_req),
   .rd_addr(rd_addr), .rd_ack(rd_ack), .done(done), .fault(fault),
   .fault_vec(fault_vec), .err_code(err_code)
);

// File: tb/idt_gate_lookup_tb.sv
module idt_gate_lookup_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic [7:0]  req_vector;
   logic [1:0]  req_src;
   logic [1:0]  req_cpl;
   logic        req_real;
   logic [63:0] b_base;
   logic [15:0] b_limit;
   logic        rd_req;
   logic [63:0] rd_addr;
   logic        rd_ack;
   logic [63:0] rd_data;
   logic        done;
   logic        fault;
   logic [7:0]  fault_vec;
   logic [15:0] err_code;
   logic [63:0] handler;
   logic [15:0] selector;
   logic [2:0]  stack_idx;
   logic        clear_if;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [3:0] k_type;
   logic [1:0] k_dpl;
   logic       k_p;
   logic       b_real;
   int         k_delay;
   int         wait_n;
   int         beat_n;
   int         ack_cyc;
   logic [63:0] addr_prev;
   logic [63:0] addr_last;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   idt_gate_lookup u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_vector(req_vector), .req_src(req_src), .req_cpl(req_cpl),
      .req_real(req_real), .tbl_base(b_base), .tbl_limit(b_limit),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .done(done), .fault(fault), .fault_vec(fault_vec), .err_code(err_code),
      .handler(handler), .selector(selector), .stack_idx(stack_idx),
      .clear_if(clear_if)
   );

   function automatic logic [63:0] hnd_of(input int n);
      return 64'hFEDC_BA98_7654_0000 + 64'(n) * 64'h0001_0003_0010_0007;
   endfunction
   function automatic logic [15:0] sel_of(input int n);
      return 16'h0008 + 16'(n);
   endfunction
   function automatic logic [2:0] ist_of(input int n);
      return 3'(n % 8);
   endfunction
   function automatic logic [15:0] seg_of(input int n);
      return 16'h1000 + 16'(n) * 16'h0101;
   endfunction
   function automatic logic [15:0] off_of(input int n);
      return 16'h0F00 + 16'(n * 3);
   endfunction

   function automatic logic [63:0] mem_word(input logic [63:0] a, input logic [63:0] base,
                                             input logic rm, input logic [3:0] ty,
                                             input logic [1:0] dp, input logic pr);
      logic [63:0] ofs;
      logic [63:0] h;
      int          n;
      if (rm) begin
         n = int'(a >> 2);
         return {32'hA5A5_5A5A, seg_of(n), off_of(n)};
      end
      ofs = a - base;
      n   = int'(ofs >> 4);
      h   = hnd_of(n);
      if (ofs[3]) return {32'hFFFF_FFFF, h[63:32]};
      return {h[31:16], pr, dp, 1'b0, ty, 5'b10101, ist_of(n), sel_of(n), h[15:0]};
   endfunction

   assign rd_data = mem_word(rd_addr, b_base, b_real, k_type, k_dpl, k_p);

   // memory model: acknowledges a pending read after k_delay idle cycles
   always @(negedge clk) begin
      if (rst) begin
         rd_ack = 1'b0;
         wait_n = 0;
      end else if (rd_ack) begin
         rd_ack = 1'b0;
         wait_n = 0;
      end else if (rd_req && wait_n >= k_delay) begin
         rd_ack    = 1'b1;
         beat_n    = beat_n + 1;
         addr_prev = addr_last;
         addr_last = rd_addr;
         ack_cyc   = cyc;
      end else begin
         wait_n = rd_req ? wait_n + 1 : 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input int n, input int src, input int cpl, input bit rm, input bit junk);
      bit          efault;
      logic [7:0]  efv;
      logic [63:0] eh;
      logic [15:0] esel;
      logic [2:0]  eist;
      logic        eclr;
      int          ebeats;
      int          b0;
      int          acc;
      int          t;
      int          dc;
      bit          busy_bad;
      string       rq;
      efault = 0; efv = 0; eh = 0; esel = 0; eist = 0; eclr = 0;
      ebeats = 2; rq = "R4"; busy_bad = 0;
      if (rm) begin
         ebeats = 1; rq = "R10";
         eh = 64'(seg_of(n)) * 16 + 64'(off_of(n));
         esel = seg_of(n); eclr = 1'b1;
      end else if (n * 16 + 15 > int'(b_limit)) begin
         efault = 1; efv = 8'd13; ebeats = 0; rq = "R6";
      end else if (k_type != 4'hE && k_type != 4'hF) begin
         efault = 1; efv = 8'd13; rq = "R5";
      end else if (src == 2 && cpl > int'(k_dpl)) begin
         efault = 1; efv = 8'd13; rq = "R7";
      end else if (!k_p) begin
         efault = 1; efv = 8'd11; rq = "R8";
      end else begin
         eh = hnd_of(n); esel = sel_of(n); eist = ist_of(n);
         eclr = (k_type == 4'hE);
      end

      b_real = rm;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vector = 8'(n); req_src = 2'(src); req_cpl = 2'(cpl);
      req_real = rm; req_valid = 1'b1;
      b0 = beat_n; acc = cyc;
      @(negedge clk);
      if (junk) begin
         req_vector = ~8'(n); req_src = 2'd2; req_cpl = 2'd3;
      end else begin
         req_valid = 1'b0;
      end
      t = 0;
      while (!done && t < 80) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
         t++;
      end
      req_valid = 1'b0;
      dc = cyc;

      chk(t < 80, "R3 done seen", 64'(t), 64'd80);
      chk(fault === efault, {rq, " fault flag"}, 64'(fault), 64'(efault));
      if (efault) begin
         chk(fault_vec === efv, {rq, " fault vector"}, 64'(fault_vec), 64'(efv));
         chk(err_code === 16'(n * 8 + 2), "R9 error code", 64'(err_code), 64'(n * 8 + 2));
      end
      chk(handler === eh, efault ? "R9 handler zero" : {rq, " handler"}, handler, eh);
      chk(selector === esel, efault ? "R9 selector zero" : {rq, " selector"}, 64'(selector), 64'(esel));
      chk(stack_idx === eist, efault ? "R9 stack idx zero" : "R4 stack idx", 64'(stack_idx), 64'(eist));
      chk(clear_if === eclr, rm ? "R10 clear_if" : "R5 clear_if", 64'(clear_if), 64'(eclr));
      chk(beat_n - b0 == ebeats, {rq, " read count"}, 64'(beat_n - b0), 64'(ebeats));
      if (ebeats == 2) begin
         chk(addr_prev === b_base + 64'(n * 16), "R3 low address", addr_prev, b_base + 64'(n * 16));
         chk(addr_last === b_base + 64'(n * 16 + 8), "R3 high address", addr_last, b_base + 64'(n * 16 + 8));
      end else if (ebeats == 1) begin
         chk(addr_last === 64'(n * 4), "R10 address", addr_last, 64'(n * 4));
      end
      if (ebeats == 0) chk(dc == acc + 1, "R6 done timing", 64'(dc), 64'(acc + 1));
      else chk(dc == ack_cyc + 1, ebeats == 2 ? "R3 done timing" : "R10 done timing",
               64'(dc), 64'(ack_cyc + 1));
      if (junk) chk(!busy_bad, "R2 ready low while busy", 64'(busy_bad), 64'd0);
      @(negedge clk);
      chk(done === 1'b0, "R3 single done pulse", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_vector = '0; req_src = '0; req_cpl = '0;
      req_real = 1'b0; b_base = 64'h0000_0040_0ABC_0000; b_limit = 16'h0FFF;
      k_type = 4'hE; k_dpl = 2'd0; k_p = 1'b1; b_real = 1'b0; k_delay = 0;
      wait_n = 0; beat_n = 0; ack_cyc = 0; rd_ack = 1'b0;
      addr_prev = '0; addr_last = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
      chk(rd_req === 1'b0, "R1 no read after reset", 64'(rd_req), 64'd0);
      chk(done === 1'b0 && fault === 1'b0, "R1 done/fault low", 64'({done, fault}), 64'd0);
      chk(handler === 64'd0, "R1 handler zero", handler, 64'd0);

      // R3 R4 R5: full table of interrupt gates, hardware and exception classes
      for (int n = 0; n < 256; n++) begin
         k_delay = n % 3;
         run(n, n % 2, n % 4, 1'b0, 1'b0);
      end

      // R5 R7: trap gates callable from every level
      k_type = 4'hF; k_dpl = 2'd3;
      for (int n = 0; n < 256; n += 7) run(n, 2, n % 4, 1'b0, 1'b0);

      // R6: short tables
      k_type = 4'hE; k_dpl = 2'd0; k_delay = 1;
      b_limit = 16'(16 * 40 - 1);
      for (int n = 30; n < 51; n++) run(n, 0, 0, 1'b0, 1'b0);
      b_limit = 16'(16 * 10 + 7);
      run(9, 1, 0, 1'b0, 1'b0);
      run(10, 1, 0, 1'b0, 1'b0);
      b_limit = 16'h0FFF;

      // R5: every type code
      for (int ty = 0; ty < 16; ty++) begin
         k_type = 4'(ty);
         run(5, 0, 0, 1'b0, 1'b0);
      end
      k_type = 4'hE;

      // R7: privilege against class
      for (int s = 0; s < 3; s++)
         for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++) begin
               k_dpl = 2'(d);
               run(128, s, c, 1'b0, 1'b0);
            end
      k_dpl = 2'd0;

      // R8: not present, and check order
      k_p = 1'b0;
      for (int n = 0; n < 32; n++) run(n, n % 3, 0, 1'b0, 1'b0);
      k_type = 4'h6;
      run(14, 0, 0, 1'b0, 1'b0);
      k_type = 4'hE;
      run(14, 2, 3, 1'b0, 1'b0);
      b_limit = 16'h001F;
      run(3, 0, 0, 1'b0, 1'b0);
      b_limit = 16'h0FFF;
      k_p = 1'b1;

      // R2: other requests held during a fetch
      k_delay = 2;
      run(33, 0, 0, 1'b0, 1'b1);
      run(200, 1, 0, 1'b0, 1'b1);
      run(77, 0, 0, 1'b1, 1'b1);

      // R10: real-mode table, protected checks not applied
      b_limit = 16'h0000; k_p = 1'b0; k_type = 4'h0;
      for (int n = 0; n < 256; n++) begin
         k_delay = n % 3;
         run(n, n % 3, 3, 1'b1, 1'b0);
      end
      b_limit = 16'h0FFF; k_p = 1'b1; k_type = 4'hE;

      // R1: reset in the middle of a fetch
      k_delay = 6; b_real = 1'b0;
      @(negedge clk);
      req_vector = 8'd12; req_src = 2'd0; req_cpl = 2'd0; req_real = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(rd_req === 1'b0, "R1 mid-fetch reset read dropped", 64'(rd_req), 64'd0);
      chk(req_ready === 1'b1, "R1 mid-fetch reset idle", 64'(req_ready), 64'd1);
      chk(done === 1'b0, "R1 mid-fetch reset no done", 64'(done), 64'd0);
      k_delay = 0;
      run(12, 0, 0, 1'b0, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule